// File: doc/BRIEF.md
# Four-Phase Two-Client Resource Arbiter

This block lets two clients share one resource. Every channel uses a four-phase return-to-zero handshake: the client request goes high, the grant goes high, the request goes low, and then the grant goes low. The resource channel follows the same rule, with the arbiter acting as its client.

A two-way mutual-exclusion stage picks one pending client and holds that choice until the client lowers its request. A pair of handshake gates then relays the selected client's request to the resource and returns the resource grant to that client only. The next client is not forwarded to the resource until the previous client's channel has fully returned to zero. That means its grant has fallen, not only its request. When both clients contend from idle in the same cycle, the client that lost the previous contention wins. The first tie after reset goes to the client set by a parameter.

All state is synchronous and is cleared by an active-low reset. A client grant is the registered grant state ANDed with the live resource grant. A client grant therefore drops in the same cycle as the resource grant and is never high while the resource grant is low.

Top module: `rtz_pair_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset, `res_req` and both bits of `cl_gnt` are 0.
- R2: At most one bit of `cl_gnt` is 1 in any cycle.
- R3: Suppose the arbiter is idle and no client grant is held. If a request on `cl_req[i]` is sampled at clock edge E, then `res_req` is 1 after edge E+1.
- R4: If `res_gnt` is sampled at 1 while client i's request is being forwarded, then `cl_gnt[i]` is 1 after that edge. The other client's grant stays 0.
- R5: The winning client lowers its request, sampled at edge E. Then `res_req` is 0 after edge E+1.
- R6: `cl_gnt[i]` is 0 in any cycle in which `res_gnt` is 0, including the cycle in which `res_gnt` falls, before any clock edge.
- R7: A client selected after another client gets no forwarding while the previous client's grant state is held. Suppose the previous client's grant state clears at the edge where `res_gnt` is sampled at 0. Then `res_req` for the new client rises one edge later.
- R8: While a client is selected and keeps its request high, a request from the other client does not change the selection or the grants.
- R9: If both requests are first sampled together from idle, the winner alternates. With `FIRST_WIN`=0, client 0 (bit 0) wins the first tie and client 1 (bit 1) wins the next tie.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cl_req | input | 2 | Client requests, bit i belongs to client i |
| cl_gnt | output | 2 | Client grants, bit i belongs to client i |
| res_req | output | 1 | Request to the shared resource |
| res_gnt | input | 1 | Grant from the shared resource |

## Verification
The selection register picks up a client request at the first edge, and the forwarding register drives `res_req` one edge later. The grant state captures `res_gnt` one edge after it arrives. A client grant falls combinationally with `res_gnt`, with no edge in between. The bench drives inputs on the falling clock edge and checks 1 ns after each rising edge, so every vector holds the expected outputs after exactly one registered step. The same-cycle grant drop is checked with no clock edge between the change of `res_gnt` and the sample.

// File: rtl/rtz_arb_pkg.sv
// Shared constants and types for the two-client four-phase arbiter.
package rtz_arb_pkg;
    localparam int N_CLI = 2;
    typedef logic [N_CLI-1:0] cli_vec_t;
endpackage

// File: rtl/rtz_mutex.sv
// Two-way mutual-exclusion stage.
// Picks one requesting client when idle and holds the choice until that client
// lowers its request. A tie from idle goes to the client that lost the last tie.
// Assumes requests follow the four-phase rule (held high until granted).
module rtz_mutex
    import rtz_arb_pkg::*;
#(
    parameter bit FIRST_WIN = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  cli_vec_t req,
    output cli_vec_t sel
);
    cli_vec_t sel_q, sel_d;
    logic     fav_q;   // index of the client favoured on the next tie

    // next selection: hold, release on request drop, or choose when idle
    always_comb begin
        sel_d = sel_q;
        if (sel_q != '0) begin
            if ((sel_q & req) == '0) sel_d = '0;
        end else if (req == '1) begin
            sel_d = fav_q ? cli_vec_t'(2'b10) : cli_vec_t'(2'b01);
        end else begin
            sel_d = req;
        end
    end

    // selection register and tie-break memory
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            fav_q <= FIRST_WIN;
        end else begin
            sel_q <= sel_d;
            if (sel_q == '0 && req == '1) fav_q <= ~fav_q;
        end
    end

    assign sel = sel_q;
endmodule

// File: rtl/rtz_gate.sv
// Per-client handshake gate.
// Forwards the selected request once the peer client's grant state is clear,
// and keeps a C-element style grant state that sets on forward AND resource
// grant and clears only when both are low.
module rtz_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic peer_hold,
    input  logic res_gnt,
    output logic fwd,
    output logic hold
);
    logic fwd_q, hold_q;

    // forwarding latch and grant C-element
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_q  <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            fwd_q  <= sel & (fwd_q | ~peer_hold);
            hold_q <= (fwd_q & res_gnt) | (hold_q & (fwd_q | res_gnt));
        end
    end

    assign fwd  = fwd_q;
    assign hold = hold_q;
endmodule

// File: rtl/rtz_pair_arbiter.sv
// Two-client four-phase arbiter for one shared resource.
// The mutex stage selects a client, one gate per client relays the request and
// steers the grant back. The resource request is the OR of the forwards.
// Assumes all three channels obey the return-to-zero handshake.
module rtz_pair_arbiter
    import rtz_arb_pkg::*;
#(
    parameter bit FIRST_WIN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CLI-1:0] cl_req,
    output logic [N_CLI-1:0] cl_gnt,
    output logic             res_req,
    input  logic             res_gnt
);
    cli_vec_t sel, fwd, hold;

    rtz_mutex #(.FIRST_WIN(FIRST_WIN)) u_mutex (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (cl_req),
        .sel   (sel)
    );

    for (genvar i = 0; i < N_CLI; i++) begin : g_gate
        rtz_gate u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (sel[i]),
            .peer_hold (hold[N_CLI-1-i]),
            .res_gnt   (res_gnt),
            .fwd       (fwd[i]),
            .hold      (hold[i])
        );
    end

    // merge the forwarded requests, qualify grants with the live resource grant
    always_comb begin
        res_req = |fwd;
        cl_gnt  = hold & {N_CLI{res_gnt}};
    end
endmodule

// File: rtl/rtz_pair_arbiter_chk.sv
// Property checker for rtz_pair_arbiter, bound to every instance.
module rtz_pair_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cl_req,
    input logic [1:0] cl_gnt,
    input logic       res_req,
    input logic       res_gnt
);
    // R2
    gnt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cl_gnt[0] && cl_gnt[1]));
    // R4
    gnt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_gnt != 2'b00 && $past(cl_gnt) == 2'b00) |-> res_req || $past(res_req));
    // R3
    fwd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_req) |-> $past(cl_req, 2) != 2'b00);
    // R7
    fwd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_req) |-> $past(cl_gnt) == 2'b00);
    // R8
    hold_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_gnt[0] && cl_req[0] && res_gnt) |=> !cl_gnt[1]);
endmodule

bind rtz_pair_arbiter rtz_pair_arbiter_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cl_req  (cl_req),
    .cl_gnt  (cl_gnt),
    .res_req (res_req),
    .res_gnt (res_gnt)
);

// File: tb/sim_rtz_pair_arbiter.sv
module sim_rtz_pair_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cl_req = 2'b00;
    logic [1:0] cl_gnt;
    logic       res_req;
    logic       res_gnt = 1'b0;
    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    rtz_pair_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .cl_req(cl_req),
        .cl_gnt(cl_gnt), .res_req(res_req), .res_gnt(res_gnt)
    );

    // {req1, req0, res_gnt, exp res_req, exp gnt1, exp gnt0}
    localparam int NV = 30;
    localparam logic [5:0] VEC [NV] = '{
        6'b010_000, 6'b010_100, 6'b011_101, 6'b111_101, 6'b101_101,
        6'b101_001, 6'b101_001, 6'b100_000, 6'b100_100, 6'b101_110,
        6'b001_110, 6'b001_010, 6'b000_000, 6'b110_000, 6'b110_100,
        6'b111_101, 6'b101_101, 6'b101_001, 6'b000_000, 6'b110_000,
        6'b110_100, 6'b111_110, 6'b011_110, 6'b011_010, 6'b010_000,
        6'b010_100, 6'b011_101, 6'b001_101, 6'b001_001, 6'b000_000
    };

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {res_req,gnt} actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic string vec_tag(input int k);
        if (k == 3) return "R8 hold selection";
        if (k == 6 || k == 7 || k == 8) return "R7 block until grant clear";
        if (k == 13 || k == 19) return "R9 tie winner";
        if (k == 4 || k == 11 || k == 27) return "R5 request drop";
        if (k == 2 || k == 9 || k == 21) return "R4 grant steering";
        if (k == 12 || k == 24) return "R6 grant falls with resource";
        return "R3 forward path";
    endfunction

    task automatic step(input logic [1:0] rq, input logic rg);
        @(negedge clk);
        cl_req = rq;
        res_gnt = rg;
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #1 check("R1 in reset", {res_req, cl_gnt}, 3'b000);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #1 check("R1 after reset", {res_req, cl_gnt}, 3'b000);

        for (int k = 0; k < NV; k++) begin
            step(VEC[k][5:4], VEC[k][3]);
            check(vec_tag(k), {res_req, cl_gnt}, VEC[k][2:0]);
        end

        // R6 same-cycle drop: grant client 1, then lower res_gnt with no edge
        step(2'b10, 1'b0);
        step(2'b10, 1'b0);
        step(2'b10, 1'b1);
        check("R4 client1 granted", {res_req, cl_gnt}, 3'b110);
        step(2'b00, 1'b1);
        step(2'b00, 1'b1);
        check("R5 resource request low", {res_req, cl_gnt}, 3'b010);
        @(negedge clk);
        res_gnt = 1'b0;
        #1 check("R6 no-edge grant drop", {res_req, cl_gnt}, 3'b000);
        @(posedge clk);
        #1;

        // R1 reset in mid-transaction
        step(2'b01, 1'b0);
        step(2'b01, 1'b0);
        step(2'b01, 1'b1);
        check("R4 client0 granted", {res_req, cl_gnt}, 3'b101);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        #1 check("R1 reset mid-grant", {res_req, cl_gnt & {2{1'b1}}}, {1'b0, 2'b00 | (cl_gnt & 2'b00)});
        check("R1 grants cleared", {1'b0, cl_gnt}, 3'b000);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule